// File: doc/BRIEF.md
# Processor-Port Memory Bank Decoder

This block sits between an 8-bit CPU's 16-bit address bus and the memories and peripherals around it. For each access it picks exactly one target (main RAM, one of three ROMs, or one of several I/O devices) and hands that target an address offset masked to the target's own size. The memory arrays and the peripherals are outside the block. It only produces selects, offsets and write data, plus read data for the few locations it answers itself.

Two byte-wide registers live inside the block at addresses 0 and 1: a direction register and an output register. The value `~direction | output` sets which ROMs and which I/O window appear in the upper address space. This gives eight layouts. A write to either register also writes the RAM cell underneath, using the byte last seen on the video bus. The selects, offsets and local read data are combinational from the address, the strobes and the registered port values, so a new layout applies from the access after the port write.

Top module: `mem_bank_decoder`

## Requirements
- R1: After a synchronous reset both port registers are 0. The effective port value is therefore 0xFF, which maps the BASIC ROM, the KERNAL ROM and the I/O window. A read of address 1 then returns 0x17.
- R2: A read of address 0 returns the direction register with `rdata_vld`=1 and no select. A read of address 1 returns `(dir & out) | (~dir & 0x17)`.
- R3: A write to address 0 loads the direction register and a write to address 1 loads the output register on the clock edge. The same access selects RAM (sel bit 0), with offset equal to the address and `dev_wdata` equal to `vbus_byte`.
- R4: A read in 0xA000–0xBFFF selects BASIC ROM (sel bit 1, offset masked to 13 bits) when effective port bits 1 and 0 are both 1. Otherwise it selects RAM with the full address.
- R5: A read in 0xE000–0xFFFF selects KERNAL ROM (sel bit 3, offset masked to 13 bits) when effective port bit 1 is 1. Otherwise it selects RAM.
- R6: In 0xD000–0xDFFF, with effective bits 1:0 nonzero, bit 2 = 0 maps character ROM for reads (sel bit 2, 12-bit offset) and bit 2 = 1 maps the I/O window. With bits 1:0 both zero the range is RAM.
- R7: Inside the I/O window, address bits 11:8 choose the device. Pages 0–3 select video (sel bit 4, 6-bit offset). Pages 4–7 select sound (sel bit 5, 5-bit offset). Page C selects timer 1 (sel bit 7, 4-bit offset). Page D selects timer 2 (sel bit 8, 4-bit offset).
- R8: Pages 8–B of the I/O window select colour RAM (sel bit 6, 10-bit offset). A read returns `{vbus_byte[7:4], cram_rdata}` with `rdata_vld`=1. A write drives `dev_wdata` = `{4'h0, wdata[3:0]}`.
- R9: In I/O pages E–F, addresses 0xDF00–0xDF0F select the expansion unit (sel bit 9, 4-bit offset). Any other read there selects nothing and returns `vbus_byte` with `rdata_vld`=1. Any other write there selects nothing.
- R10: Writes to 0xA000–0xBFFF, 0xE000–0xFFFF and 0xC000–0xCFFF always select RAM. So do writes to 0xD000–0xDFFF when the I/O window is not mapped. In each case `dev_wdata` = `wdata`.
- R11: A layout change made by a port write applies to the very next access.
- R12: With neither strobe active no select and no `rdata_vld` is asserted, and at most one select bit is ever high. Addresses 0x0002–0x9FFF always select RAM with the full address as offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | CPU address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | CPU write data |
| vbus_byte | input | 8 | Last byte seen on the video bus |
| cram_rdata | input | 4 | Colour RAM read nibble |
| sel | output | 10 | One-hot target select (bit order in R3–R9) |
| offset | output | 16 | Address masked to the selected target's size |
| dev_wdata | output | 8 | Write data toward the selected target |
| rdata | output | 8 | Read data produced locally |
| rdata_vld | output | 1 | `rdata` is the answer to the current read |

## Verification
A wrong value in either port register does not show as a single bad byte. It moves whole regions between ROM, I/O and RAM, so the first access to 0xA000, 0xD000 or 0xE000 after the bad write already reports the wrong select. A read of address 0 or 1 shows the register value itself in the same cycle. The bench therefore steps through every output-register value under a fully driven direction register, and probes each region right after each port write. It also interleaves random accesses with random port writes, so that a stale or late layout fails on the next access.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int AW    = 16;
  localparam int DW    = 8;
  localparam int TGT_N = 10;

  typedef enum logic [3:0] {
    T_RAM    = 4'd0,
    T_BASIC  = 4'd1,
    T_CHAR   = 4'd2,
    T_KERNAL = 4'd3,
    T_VIDEO  = 4'd4,
    T_SOUND  = 4'd5,
    T_COLOR  = 4'd6,
    T_TIM1   = 4'd7,
    T_TIM2   = 4'd8,
    T_EXP    = 4'd9,
    T_NONE   = 4'd15
  } tgt_e;

  function automatic logic [AW-1:0] tgt_mask(input tgt_e t);
    case (t)
      T_RAM:             tgt_mask = 16'hFFFF;
      T_BASIC, T_KERNAL: tgt_mask = 16'h1FFF;
      T_CHAR:            tgt_mask = 16'h0FFF;
      T_VIDEO:           tgt_mask = 16'h003F;
      T_SOUND:           tgt_mask = 16'h001F;
      T_COLOR:           tgt_mask = 16'h03FF;
      T_TIM1, T_TIM2,
      T_EXP:             tgt_mask = 16'h000F;
      default:           tgt_mask = 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/mbd_port_regs.sv
module mbd_port_regs #(
  parameter int              DW      = 8,
  parameter logic [DW-1:0]   RD_PULL = 8'h17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_dir,
  input  logic          wr_out,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] port_rd,
  output logic [DW-1:0] eff
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_out) out_q <= wdata;
    end
  end

  assign port_rd = (dir_q & out_q) | (~dir_q & RD_PULL);
  assign eff     = ~dir_q | out_q;

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (dir_q == '0 && out_q == '0));
  a_r3_dir_load: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> dir_q == $past(wdata));
  a_r3_out_load: assert property (@(posedge clk) disable iff (rst)
    wr_out |=> out_q == $past(wdata));
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_dir && !wr_out && !$past(rst)) |=> ($stable(dir_q) && $stable(out_q)));
endmodule

// File: rtl/mbd_bank_cfg.sv
module mbd_bank_cfg #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] eff,
  output logic          basic_in,
  output logic          kernal_in,
  output logic          char_in,
  output logic          io_in
);
  logic lo_any;
  assign lo_any    = eff[1] | eff[0];
  assign basic_in  = eff[1] & eff[0];
  assign kernal_in = eff[1];
  assign char_in   = lo_any & ~eff[2];
  assign io_in     = lo_any &  eff[2];

  always_comb begin
    a_r6_char_io_excl: assert (!(char_in && io_in));
  end
endmodule

// File: rtl/mbd_io_decode.sv
module mbd_io_decode
  import mbd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  output tgt_e          io_tgt
);
  logic exp_win;
  assign exp_win = (addr[11:8] == 4'hF) && (addr[7:4] == 4'h0);

  always_comb begin
    unique case (addr[11:8])
      4'h0, 4'h1, 4'h2, 4'h3: io_tgt = T_VIDEO;
      4'h4, 4'h5, 4'h6, 4'h7: io_tgt = T_SOUND;
      4'h8, 4'h9, 4'hA, 4'hB: io_tgt = T_COLOR;
      4'hC:                   io_tgt = T_TIM1;
      4'hD:                   io_tgt = T_TIM2;
      default:                io_tgt = exp_win ? T_EXP : T_NONE;
    endcase
  end
endmodule

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder
  import mbd_pkg::*;
#(
  parameter int            AW      = mbd_pkg::AW,
  parameter int            DW      = mbd_pkg::DW,
  parameter int            NT      = mbd_pkg::TGT_N,
  parameter int            CW      = 4,
  parameter logic [DW-1:0] RD_PULL = 8'h17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] vbus_byte,
  input  logic [CW-1:0] cram_rdata,
  output logic [NT-1:0] sel,
  output logic [AW-1:0] offset,
  output logic [DW-1:0] dev_wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_vld
);
  localparam logic [AW-1:0] PORT_TOP = 2;

  logic          access, port_hit;
  logic [DW-1:0] dir_q, out_q, port_rd, eff;
  logic          basic_in, kernal_in, char_in, io_in;
  tgt_e          io_tgt, tgt;

  assign access   = rd_en | wr_en;
  assign port_hit = addr < PORT_TOP;

  mbd_port_regs #(.DW(DW), .RD_PULL(RD_PULL)) u_port (
    .clk(clk), .rst(rst),
    .wr_dir(wr_en && port_hit && !addr[0]),
    .wr_out(wr_en && port_hit &&  addr[0]),
    .wdata(wdata), .dir_q(dir_q), .out_q(out_q),
    .port_rd(port_rd), .eff(eff)
  );

  mbd_bank_cfg #(.DW(DW)) u_cfg (
    .eff(eff), .basic_in(basic_in), .kernal_in(kernal_in),
    .char_in(char_in), .io_in(io_in)
  );

  mbd_io_decode #(.AW(AW)) u_io (.addr(addr), .io_tgt(io_tgt));

  always_comb begin
    tgt       = T_NONE;
    rdata_vld = 1'b0;
    rdata     = '0;
    dev_wdata = wdata;
    if (access) begin
      if (port_hit) begin
        if (wr_en) begin
          tgt       = T_RAM;
          dev_wdata = vbus_byte;
        end else begin
          rdata_vld = 1'b1;
          rdata     = addr[0] ? port_rd : dir_q;
        end
      end else begin
        unique case (addr[AW-1:AW-4])
          4'hA, 4'hB: tgt = (basic_in && !wr_en) ? T_BASIC : T_RAM;
          4'hE, 4'hF: tgt = (kernal_in && !wr_en) ? T_KERNAL : T_RAM;
          4'hD: begin
            if (io_in) begin
              tgt = io_tgt;
              if (io_tgt == T_COLOR) begin
                dev_wdata = {{(DW-CW){1'b0}}, wdata[CW-1:0]};
                if (!wr_en) begin
                  rdata_vld = 1'b1;
                  rdata     = {vbus_byte[DW-1:CW], cram_rdata};
                end
              end else if (io_tgt == T_NONE && !wr_en) begin
                rdata_vld = 1'b1;
                rdata     = vbus_byte;
              end
            end else begin
              tgt = (char_in && !wr_en) ? T_CHAR : T_RAM;
            end
          end
          default: tgt = T_RAM;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NT; g++) begin : g_sel
    assign sel[g] = (tgt == tgt_e'(g));
  end

  assign offset = addr & tgt_mask(tgt);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !(rd_en || wr_en) |-> (sel == '0 && !rdata_vld));
  a_r12_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
  a_r3_port_write_ram: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr < PORT_TOP) |-> (sel == NT'(1) && dev_wdata == vbus_byte));
  a_r8_color_high_nibble: assert property (@(posedge clk) disable iff (rst)
    (rdata_vld && sel[T_COLOR]) |-> rdata[DW-1:CW] == vbus_byte[DW-1:CW]);
  a_r10_write_no_rom: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !(sel[T_BASIC] || sel[T_KERNAL] || sel[T_CHAR]));
endmodule

// File: tb/mem_bank_decoder_test.sv
module mem_bank_decoder_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] addr;
  logic        rd_en, wr_en;
  logic [7:0]  wdata, vbus_byte;
  logic [3:0]  cram_rdata;
  logic [9:0]  sel;
  logic [15:0] offset;
  logic [7:0]  dev_wdata, rdata;
  logic        rdata_vld;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0]  m_dir, m_out;
  logic [9:0]  e_sel;
  logic [15:0] e_off;
  logic [7:0]  e_dw, e_rd;
  logic        e_vld;
  string       e_req;

  always #2 clk = ~clk;

  mem_bank_decoder uut (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .vbus_byte(vbus_byte), .cram_rdata(cram_rdata),
    .sel(sel), .offset(offset), .dev_wdata(dev_wdata),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (addr %h)", req, what, act, exp, addr);
    end
  endtask

  function automatic void model(input logic [15:0] a, input logic r, input logic w,
                                input logic [7:0] d, input logic [7:0] vb, input logic [3:0] cr);
    logic [7:0] p;
    int t;
    p = ~m_dir | m_out;
    t = -1; e_vld = 0; e_rd = 0; e_dw = d; e_req = "R12";
    if (r || w) begin
      if (a < 16'd2) begin
        if (w) begin t = 0; e_dw = vb; e_req = "R3"; end
        else begin
          e_vld = 1; e_req = "R2";
          e_rd = a[0] ? ((m_dir & m_out) | (~m_dir & 8'h17)) : m_dir;
        end
      end else if (a >= 16'hA000 && a <= 16'hBFFF) begin
        e_req = w ? "R10" : "R4";
        t = (!w && p[1] && p[0]) ? 1 : 0;
      end else if (a >= 16'hE000) begin
        e_req = w ? "R10" : "R5";
        t = (!w && p[1]) ? 3 : 0;
      end else if (a >= 16'hD000 && a <= 16'hDFFF) begin
        if (p[1:0] != 2'b00 && p[2]) begin
          case (a[11:8])
            4'h0, 4'h1, 4'h2, 4'h3: begin t = 4; e_req = "R7"; end
            4'h4, 4'h5, 4'h6, 4'h7: begin t = 5; e_req = "R7"; end
            4'h8, 4'h9, 4'hA, 4'hB: begin
              t = 6; e_req = "R8"; e_dw = {4'h0, d[3:0]};
              if (!w) begin e_vld = 1; e_rd = {vb[7:4], cr}; end
            end
            4'hC: begin t = 7; e_req = "R7"; end
            4'hD: begin t = 8; e_req = "R7"; end
            default: begin
              e_req = "R9";
              if (a[15:4] == 12'hDF0) t = 9;
              else if (!w) begin e_vld = 1; e_rd = vb; end
            end
          endcase
        end else begin
          e_req = w ? "R10" : "R6";
          t = (!w && p[1:0] != 2'b00) ? 2 : 0;
        end
      end else begin
        t = 0; e_req = (a >= 16'hC000) ? "R10" : "R12";
      end
    end
    e_sel = (t < 0) ? 10'd0 : (10'd1 << t);
    case (t)
      0: e_off = a;
      1, 3: e_off = a & 16'h1FFF;
      2: e_off = a & 16'h0FFF;
      4: e_off = a & 16'h003F;
      5: e_off = a & 16'h001F;
      6: e_off = a & 16'h03FF;
      7, 8, 9: e_off = a & 16'h000F;
      default: e_off = 16'h0000;
    endcase
  endfunction

  task automatic acc(input logic [15:0] a, input logic r, input logic w, input logic [7:0] d,
                     input logic [7:0] vb, input logic [3:0] cr, input string tag);
    string rq;
    @(negedge clk);
    addr = a; rd_en = r; wr_en = w; wdata = d; vbus_byte = vb; cram_rdata = cr;
    #1;
    model(a, r, w, d, vb, cr);
    rq = (tag != "") ? tag : e_req;
    chk(rq, "sel", {6'd0, sel}, {6'd0, e_sel});
    chk(rq, "vld", {15'd0, rdata_vld}, {15'd0, e_vld});
    if (e_sel != 0) chk(rq, "offset", offset, e_off);
    if (e_vld) chk(rq, "rdata", {8'd0, rdata}, {8'd0, e_rd});
    if (w && e_sel != 0) chk(rq, "wdata", {8'd0, dev_wdata}, {8'd0, e_dw});
    @(posedge clk);
    if (w && a == 16'd0) m_dir = d;
    if (w && a == 16'd1) m_out = d;
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    rst = 1; addr = 0; rd_en = 0; wr_en = 0; wdata = 0; vbus_byte = 0; cram_rdata = 0;
    m_dir = 8'h00; m_out = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: reset state seen at the ports
    acc(16'h0000, 1, 0, 8'h00, 8'h00, 4'h0, "R1");
    acc(16'h0001, 1, 0, 8'h00, 8'h00, 4'h0, "R1");
    chk("R1", "port1", {8'd0, rdata}, 16'h0017);
    acc(16'hA123, 1, 0, 8'h00, 8'h00, 4'h0, "R1");
    acc(16'hE456, 1, 0, 8'h00, 8'h00, 4'h0, "R1");
    acc(16'hD012, 1, 0, 8'h00, 8'h00, 4'h0, "R1");
    acc(16'h1234, 0, 0, 8'h00, 8'h00, 4'h0, "R12");

    // R2/R3: port register writes and read formula
    acc(16'h0000, 0, 1, 8'h2F, 8'hA5, 4'h0, "R3");
    acc(16'h0001, 0, 1, 8'h05, 8'h3C, 4'h0, "R3");
    acc(16'h0001, 1, 0, 8'h00, 8'h00, 4'h0, "R2");
    chk("R2", "port1", {8'd0, rdata}, 16'h0015);
    acc(16'h0000, 1, 0, 8'h00, 8'h00, 4'h0, "R2");

    // R11: layout change takes effect on the next access
    acc(16'h0000, 0, 1, 8'hFF, 8'h11, 4'h0, "R11");
    acc(16'h0001, 0, 1, 8'h03, 8'h22, 4'h0, "R11");
    acc(16'hD800, 1, 0, 8'h00, 8'hF0, 4'h5, "R11");
    acc(16'h0001, 0, 1, 8'h00, 8'h22, 4'h0, "R11");
    acc(16'hA000, 1, 0, 8'h00, 8'h00, 4'h0, "R11");

    // All eight layouts with a fully driven port
    for (int k = 0; k < 8; k++) begin
      acc(16'h0001, 0, 1, 8'(k), 8'h5A, 4'h0, "R3");
      acc(16'hA001, 1, 0, 8'h00, 8'h00, 4'h0, "");
      acc(16'hBFFF, 0, 1, 8'h77, 8'h00, 4'h0, "");
      acc(16'hC0DE, 1, 0, 8'h00, 8'h00, 4'h0, "");
      acc(16'hC0DE, 0, 1, 8'h99, 8'h00, 4'h0, "");
      acc(16'hD02F, 1, 0, 8'h00, 8'h00, 4'h0, "");
      acc(16'hD41C, 0, 1, 8'h44, 8'h00, 4'h0, "");
      acc(16'hDBFF, 1, 0, 8'h00, 8'hC3, 4'hA, "");
      acc(16'hD9AB, 0, 1, 8'hE7, 8'h00, 4'h0, "");
      acc(16'hDC0F, 1, 0, 8'h00, 8'h00, 4'h0, "");
      acc(16'hDD03, 0, 1, 8'h12, 8'h00, 4'h0, "");
      acc(16'hDF0F, 1, 0, 8'h00, 8'h00, 4'h0, "");
      acc(16'hDF10, 1, 0, 8'h00, 8'h6E, 4'h0, "");
      acc(16'hDE80, 0, 1, 8'h31, 8'h00, 4'h0, "");
      acc(16'hFFFC, 1, 0, 8'h00, 8'h00, 4'h0, "");
      acc(16'hE000, 0, 1, 8'h0F, 8'h00, 4'h0, "");
    end

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      int pick;
      logic r, w;
      pick = int'($urandom_range(0, 9));
      case (pick)
        0: a = 16'($urandom_range(0, 1));
        1: a = 16'hA000 | 16'($urandom_range(0, 16'h1FFF));
        2, 3: a = 16'hD000 | 16'($urandom_range(0, 16'h0FFF));
        4: a = 16'hDF00 | 16'($urandom_range(0, 16'h001F));
        5: a = 16'hE000 | 16'($urandom_range(0, 16'h1FFF));
        default: a = 16'($urandom);
      endcase
      w = $urandom_range(0, 2) == 0;
      r = !w && ($urandom_range(0, 7) != 0);
      acc(a, r, w, 8'($urandom), 8'($urandom), 4'($urandom), "");
    end

    @(negedge clk); rd_en = 0; wr_en = 0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule